// File: doc/BRIEF.md
# Stack and Subroutine Bus Sequencer

This block runs the memory-cycle sequences of an 8-bit CPU that touch the hardware stack or transfer control through it. The seven sequences are software break, subroutine call, subroutine return, byte push, byte pull, flag push and flag pull. The stack sits in one fixed page of a 16-bit address space. The stack pointer is 8 bits wide and is the offset inside that page. The host core pulses `start` with an operation code and supplies the current program counter, stack pointer, flag set and, for a byte push, the byte to store. The sequencer then owns a single-port memory bus and issues exactly one access per clock. Dummy reads are issued at the same points where the CPU itself would issue them.

When the last access has been made, the sequencer raises `done` for one cycle and presents the updated program counter, stack pointer, flags and pulled byte. The memory returns read data combinationally in the cycle of the access. Instruction decode, arithmetic and interrupt sources are handled by other blocks.

Top module: `stk_call_seq`

## Requirements
- R1: After reset the bus is quiet (`mem_rd`, `mem_wr` and `done` low) and `pc_out`, `sp_out`, `flags_out` and `byte_out` read zero.
- R2: Every stack access uses address `{STACK_PAGE, S}`, which is 0x01SS by default. Every write the block makes is a stack write.
- R3: Operation code 3 (byte push) writes `byte_in` at the stack address and then decrements S. `byte_out` then echoes `byte_in`. In every operation except byte pull, `byte_out` equals the `byte_in` given at start.
- R4: Operation code 4 (byte pull) performs a dummy read at the stack address, increments S and then reads the stack address again. The byte from that second read appears on `byte_out`.
- R5: Operation code 5 (flag push) writes one status byte and decrements S. Flag input bits are N=5, V=4, D=3, I=2, Z=1, C=0. The byte carries C in bit 0, Z in bit 1, I in bit 2, D in bit 3, ones in bits 4 and 5, V in bit 6 and N in bit 7.
- R6: Operation code 6 (flag pull) follows the pull pattern of R4. It loads N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of the pulled byte. Bits 4 and 5 of that byte have no effect.
- R7: Operation code 1 (call) reads the target low byte at PC and increments PC. It then makes a dummy read at the stack address, pushes PC high and then PC low, reads the target high byte at PC, and loads PC with the target.
- R8: Operation code 2 (return) makes a dummy read at PC and a dummy read at the stack address, then increments S. It reads PC low from the stack, increments S again and reads PC high. Finally it makes a dummy read at the pulled PC and increments PC by one.
- R9: Operation code 0 (break) makes a dummy read at PC and increments PC. It pushes PC high, PC low and the R5 status byte built from the incoming flags, and then sets the I flag. It loads PC low from `VEC_ADDR` (0xFFFE) and PC high from `VEC_ADDR+1`.
- R10: While a sequence runs, exactly one of `mem_rd` and `mem_wr` is high in each cycle. Both are low otherwise. `done` is a single-cycle pulse in the cycle after the last access.
- R11: S wraps modulo 256. A push at S=0x00 leaves 0xFF, and a pull at S=0xFF reads address `{STACK_PAGE, 0x00}`.
- R12: A start pulse is taken only when the block is idle. A start that arrives during a running sequence does not alter it and adds no accesses. Operation code 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| op | input | 3 | Operation code (0 break, 1 call, 2 return, 3 byte push, 4 byte pull, 5 flag push, 6 flag pull, 7 none) |
| pc_in | input | 16 | Program counter at start |
| sp_in | input | 8 | Stack pointer at start |
| flags_in | input | 6 | Flags at start: N,V,D,I,Z,C in bits 5..0 |
| byte_in | input | 8 | Byte to push for operation code 3 |
| mem_rdata | input | 8 | Read data, valid in the access cycle |
| mem_addr | output | 16 | Access address |
| mem_rd | output | 1 | Read strobe (real or dummy read) |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 8 | Updated stack pointer |
| flags_out | output | 6 | Updated flags, same layout as `flags_in` |
| byte_out | output | 8 | Pulled byte (code 4), otherwise `byte_in` |

## Verification
Start is captured on a rising edge. Access number k of the sequence (counting from 1) is on the bus during the k-th cycle after that edge, and `done` follows in the cycle after the final access. The bench therefore checks timing through ordering rather than fixed delays. The driver queues every expected access and the final result at the moment it issues start. The monitor samples on the falling edge and pops one queued access for each strobe it sees. When `done` arrives, the access queue must be empty and the previous cycle must have carried a strobe. This detects an access that is missing, extra, reordered or early.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

   localparam int unsigned ADDR_W = 16;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned SP_W   = 8;
   localparam int unsigned FLAG_W = 6;
   localparam int unsigned STEP_W = 3;

   // flag vector positions
   localparam int unsigned FL_C = 0;
   localparam int unsigned FL_Z = 1;
   localparam int unsigned FL_I = 2;
   localparam int unsigned FL_D = 3;
   localparam int unsigned FL_V = 4;
   localparam int unsigned FL_N = 5;

   typedef enum logic [2:0] {
      OP_BREAK      = 3'd0,
      OP_CALL       = 3'd1,
      OP_RETURN     = 3'd2,
      OP_PUSH_BYTE  = 3'd3,
      OP_PULL_BYTE  = 3'd4,
      OP_PUSH_FLAGS = 3'd5,
      OP_PULL_FLAGS = 3'd6,
      OP_NONE       = 3'd7
   } seq_op_e;

   typedef enum logic [1:0] {ACC_READ, ACC_WRITE, ACC_PEEK} acc_e;
   typedef enum logic [1:0] {AS_PC, AS_STACK, AS_VEC_LO, AS_VEC_HI} asrc_e;
   typedef enum logic [1:0] {WS_PC_HI, WS_PC_LO, WS_FLAGS, WS_BYTE} wsrc_e;
   typedef enum logic [2:0] {CAP_NONE, CAP_TEMP, CAP_JUMP, CAP_BYTE, CAP_FLAGS} cap_e;
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_state_e;

   typedef struct packed {
      acc_e  acc;
      asrc_e asrc;
      wsrc_e wsrc;
      cap_e  cap;
      logic  pc_inc;
      logic  sp_inc;
      logic  sp_dec;
      logic  irq_off;
      logic  last;
   } step_t;

endpackage

// File: rtl/stk_status_codec.sv
module stk_status_codec
   import stk_seq_pkg::*;
#(
   parameter int unsigned       NFLAGS    = FLAG_W,
   parameter logic [DATA_W-1:0] FIXED_ONE = 8'h30
) (
   input  logic [NFLAGS-1:0] flags,
   output logic [DATA_W-1:0] flag_byte,
   input  logic [DATA_W-1:0] pulled_byte,
   output logic [NFLAGS-1:0] pulled_flags
);

   // bit of the status byte that carries flag k
   function automatic int unsigned flag_pos(int unsigned k);
      return (k < 4) ? k : k + 2;
   endfunction

   if (NFLAGS != 6) begin : g_bad_flags
      $error("stk_status_codec: six flags expected");
   end

   for (genvar k = 0; k < NFLAGS; k++) begin : g_map
      assign flag_byte[flag_pos(k)] = flags[k];
      assign pulled_flags[k]        = pulled_byte[flag_pos(k)];
   end
   assign flag_byte[5:4] = FIXED_ONE[5:4];

   // bits 4 and 5 of a pulled byte are dropped
   logic [1:0] unused_fixed;
   assign unused_fixed = pulled_byte[5:4];

endmodule

// File: rtl/stk_step_rom.sv
module stk_step_rom
   import stk_seq_pkg::*;
(
   input  seq_op_e           op,
   input  logic [STEP_W-1:0] step,
   output step_t             st
);

   function automatic step_t mk(acc_e a, asrc_e s, wsrc_e w, cap_e c,
                                logic pi, logic si, logic sd, logic io, logic l);
      step_t t;
      t.acc = a;  t.asrc = s;  t.wsrc = w;  t.cap = c;
      t.pc_inc = pi;  t.sp_inc = si;  t.sp_dec = sd;
      t.irq_off = io;  t.last = l;
      return t;
   endfunction

   localparam step_t STOP = '{acc: ACC_PEEK, asrc: AS_PC, wsrc: WS_BYTE,
                              cap: CAP_NONE, pc_inc: 1'b0, sp_inc: 1'b0,
                              sp_dec: 1'b0, irq_off: 1'b0, last: 1'b1};

   always_comb begin
      st = STOP;
      unique case (op)
         OP_BREAK: case (step)
            3'd0: st = mk(ACC_PEEK,  AS_PC,     WS_BYTE,  CAP_NONE, 1, 0, 0, 0, 0);
            3'd1: st = mk(ACC_WRITE, AS_STACK,  WS_PC_HI, CAP_NONE, 0, 0, 1, 0, 0);
            3'd2: st = mk(ACC_WRITE, AS_STACK,  WS_PC_LO, CAP_NONE, 0, 0, 1, 0, 0);
            3'd3: st = mk(ACC_WRITE, AS_STACK,  WS_FLAGS, CAP_NONE, 0, 0, 1, 1, 0);
            3'd4: st = mk(ACC_READ,  AS_VEC_LO, WS_BYTE,  CAP_TEMP, 0, 0, 0, 0, 0);
            3'd5: st = mk(ACC_READ,  AS_VEC_HI, WS_BYTE,  CAP_JUMP, 0, 0, 0, 0, 1);
            default: st = STOP;
         endcase
         OP_CALL: case (step)
            3'd0: st = mk(ACC_READ,  AS_PC,    WS_BYTE,  CAP_TEMP, 1, 0, 0, 0, 0);
            3'd1: st = mk(ACC_PEEK,  AS_STACK, WS_BYTE,  CAP_NONE, 0, 0, 0, 0, 0);
            3'd2: st = mk(ACC_WRITE, AS_STACK, WS_PC_HI, CAP_NONE, 0, 0, 1, 0, 0);
            3'd3: st = mk(ACC_WRITE, AS_STACK, WS_PC_LO, CAP_NONE, 0, 0, 1, 0, 0);
            3'd4: st = mk(ACC_READ,  AS_PC,    WS_BYTE,  CAP_JUMP, 0, 0, 0, 0, 1);
            default: st = STOP;
         endcase
         OP_RETURN: case (step)
            3'd0: st = mk(ACC_PEEK, AS_PC,    WS_BYTE, CAP_NONE, 0, 0, 0, 0, 0);
            3'd1: st = mk(ACC_PEEK, AS_STACK, WS_BYTE, CAP_NONE, 0, 1, 0, 0, 0);
            3'd2: st = mk(ACC_READ, AS_STACK, WS_BYTE, CAP_TEMP, 0, 1, 0, 0, 0);
            3'd3: st = mk(ACC_READ, AS_STACK, WS_BYTE, CAP_JUMP, 0, 0, 0, 0, 0);
            3'd4: st = mk(ACC_PEEK, AS_PC,    WS_BYTE, CAP_NONE, 1, 0, 0, 0, 1);
            default: st = STOP;
         endcase
         OP_PUSH_BYTE:  st = mk(ACC_WRITE, AS_STACK, WS_BYTE,  CAP_NONE, 0, 0, 1, 0, 1);
         OP_PUSH_FLAGS: st = mk(ACC_WRITE, AS_STACK, WS_FLAGS, CAP_NONE, 0, 0, 1, 0, 1);
         OP_PULL_BYTE, OP_PULL_FLAGS: case (step)
            3'd0: st = mk(ACC_PEEK, AS_STACK, WS_BYTE, CAP_NONE, 0, 1, 0, 0, 0);
            3'd1: st = mk(ACC_READ, AS_STACK, WS_BYTE,
                          (op == OP_PULL_BYTE) ? CAP_BYTE : CAP_FLAGS, 0, 0, 0, 0, 1);
            default: st = STOP;
         endcase
         default: st = STOP;
      endcase
   end

endmodule

// File: rtl/stk_seq_bus.sv
module stk_seq_bus
   import stk_seq_pkg::*;
#(
   parameter logic [SP_W-1:0]   STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE
) (
   input  logic              running,
   input  acc_e              acc,
   input  asrc_e             asrc,
   input  wsrc_e             wsrc,
   input  logic [ADDR_W-1:0] pc,
   input  logic [SP_W-1:0]   sp,
   input  logic [DATA_W-1:0] flag_byte,
   input  logic [DATA_W-1:0] push_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR | 16'h0001;

   always_comb begin
      unique case (asrc)
         AS_PC:     mem_addr = pc;
         AS_STACK:  mem_addr = {STACK_PAGE, sp};
         AS_VEC_LO: mem_addr = VEC_ADDR;
         default:   mem_addr = VEC_HI_ADDR;
      endcase
      unique case (wsrc)
         WS_PC_HI: mem_wdata = pc[ADDR_W-1:DATA_W];
         WS_PC_LO: mem_wdata = pc[DATA_W-1:0];
         WS_FLAGS: mem_wdata = flag_byte;
         default:  mem_wdata = push_byte;
      endcase
      mem_wr = running && (acc == ACC_WRITE);
      mem_rd = running && (acc != ACC_WRITE);
   end

endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
   import stk_seq_pkg::*;
#(
   parameter logic [SP_W-1:0]   STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [SP_W-1:0]   sp_in,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [DATA_W-1:0] byte_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done,
   output logic [ADDR_W-1:0] pc_out,
   output logic [SP_W-1:0]   sp_out,
   output logic [FLAG_W-1:0] flags_out,
   output logic [DATA_W-1:0] byte_out
);

   if (VEC_ADDR[0] != 1'b0) begin : g_bad_vec
      $error("stk_call_seq: VEC_ADDR must be even");
   end
   if (STACK_PAGE == VEC_ADDR[ADDR_W-1:DATA_W]) begin : g_bad_page
      $error("stk_call_seq: stack page overlaps vector page");
   end

   seq_state_e          state_q;
   seq_op_e             op_q;
   logic [STEP_W-1:0]   step_q;
   logic [ADDR_W-1:0]   pc_q;
   logic [SP_W-1:0]     sp_q;
   logic [FLAG_W-1:0]   fl_q;
   logic [DATA_W-1:0]   tmp_q;
   logic [DATA_W-1:0]   byte_q;
   step_t               st;
   logic                running;
   logic [DATA_W-1:0]   flag_byte;
   logic [FLAG_W-1:0]   pulled_flags;

   assign running = (state_q == ST_RUN);

   stk_step_rom u_rom (
      .op   (op_q),
      .step (step_q),
      .st   (st)
   );

   stk_status_codec u_codec (
      .flags        (fl_q),
      .flag_byte    (flag_byte),
      .pulled_byte  (mem_rdata),
      .pulled_flags (pulled_flags)
   );

   stk_seq_bus #(
      .STACK_PAGE (STACK_PAGE),
      .VEC_ADDR   (VEC_ADDR)
   ) u_bus (
      .running   (running),
      .acc       (st.acc),
      .asrc      (st.asrc),
      .wsrc      (st.wsrc),
      .pc        (pc_q),
      .sp        (sp_q),
      .flag_byte (flag_byte),
      .push_byte (byte_q),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         step_q  <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         fl_q    <= '0;
         tmp_q   <= '0;
         byte_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start && (seq_op_e'(op) != OP_NONE)) begin
               op_q    <= seq_op_e'(op);
               step_q  <= '0;
               pc_q    <= pc_in;
               sp_q    <= sp_in;
               fl_q    <= flags_in;
               byte_q  <= byte_in;
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (st.pc_inc) pc_q <= pc_q + 1'b1;
               if (st.sp_inc) sp_q <= sp_q + 1'b1;
               else if (st.sp_dec) sp_q <= sp_q - 1'b1;
               unique case (st.cap)
                  CAP_TEMP:  tmp_q  <= mem_rdata;
                  CAP_JUMP:  pc_q   <= {mem_rdata, tmp_q};
                  CAP_BYTE:  byte_q <= mem_rdata;
                  CAP_FLAGS: fl_q   <= pulled_flags;
                  default: ;
               endcase
               if (st.irq_off) fl_q[FL_I] <= 1'b1;
               step_q <= step_q + 1'b1;
               if (st.last) state_q <= ST_FIN;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = (state_q == ST_FIN);
   assign pc_out    = pc_q;
   assign sp_out    = sp_q;
   assign flags_out = fl_q;
   assign byte_out  = byte_q;

   // R10: one strobe per running cycle, none otherwise
   a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (mem_rd != mem_wr));
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!mem_rd && !mem_wr));
   a_r10_done_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_rd || mem_wr));
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: writes land in the stack page
   a_r2_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));
   // R3: each write is followed by a decrement of S
   a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> (sp_out == $past(sp_out) - 8'd1));
   // R5: pushed status byte carries ones in bits 4 and 5
   a_r5_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && st.wsrc == WS_FLAGS) |-> (mem_wdata[5:4] == 2'b11));
   // R9: break leaves interrupts disabled
   a_r9_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_BREAK) |-> flags_out[FL_I]);
   // R12: a start during a run neither aborts nor restarts it
   a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start) |=> (running || done));

endmodule

// File: tb/stk_call_seq_test.sv
module stk_call_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd7;
   logic [15:0] pc_in = '0;
   logic [7:0]  sp_in = '0;
   logic [5:0]  flags_in = '0;
   logic [7:0]  byte_in = '0;
   logic [7:0]  mem_rdata;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, done;
   logic [7:0]  mem_wdata;
   logic [15:0] pc_out;
   logic [7:0]  sp_out;
   logic [5:0]  flags_out;
   logic [7:0]  byte_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit prev_acc = 1'b0;

   always #5 clk = ~clk;

   stk_call_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
      .sp_in(sp_in), .flags_in(flags_in), .byte_in(byte_in),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done), .pc_out(pc_out),
      .sp_out(sp_out), .flags_out(flags_out), .byte_out(byte_out)
   );

   // memory model: stack page writable, the rest a fixed pattern
   logic [7:0] stk [256];
   logic [7:0] exp_stk [256];

   function automatic logic [7:0] pat(logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction
   function automatic logic [7:0] peek(logic [15:0] a);
      return (a[15:8] == 8'h01) ? exp_stk[a[7:0]] : pat(a);
   endfunction
   function automatic logic [7:0] pack(logic [5:0] f);
      return {f[5], f[4], 2'b11, f[3:0]};
   endfunction
   function automatic logic [5:0] unpack(logic [7:0] b);
      return {b[7], b[6], b[3:0]};
   endfunction

   always_comb mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : pat(mem_addr);
   always @(posedge clk) if (mem_wr && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

   // scoreboard queues
   logic        q_wr[$];
   logic [15:0] q_addr[$];
   logic [7:0]  q_data[$];
   string       q_tag[$];
   logic [15:0] r_pc[$];
   logic [7:0]  r_sp[$];
   logic [5:0]  r_fl[$];
   logic [7:0]  r_by[$];
   string       r_tag[$];

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic exp_rd(logic [15:0] a, string tag);
      q_wr.push_back(1'b0); q_addr.push_back(a); q_data.push_back(8'h00); q_tag.push_back(tag);
   endtask
   task automatic exp_wr(logic [15:0] a, logic [7:0] d, string tag);
      q_wr.push_back(1'b1); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
      exp_stk[a[7:0]] = d;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_rd || mem_wr) begin
            if (q_addr.size() == 0) begin
               chk(1'b0, "R12", "unexpected access addr", {16'h0, mem_addr}, 32'h0);
            end else begin
               logic        w;
               logic [15:0] a;
               logic [7:0]  d;
               string       t;
               w = q_wr.pop_front(); a = q_addr.pop_front();
               d = q_data.pop_front(); t = q_tag.pop_front();
               chk(mem_wr == w && mem_rd == !w, t, "strobe wr", {31'h0, mem_wr}, {31'h0, w});
               chk(mem_addr == a, t, "addr", {16'h0, mem_addr}, {16'h0, a});
               if (w) chk(mem_wdata == d, t, "wdata", {24'h0, mem_wdata}, {24'h0, d});
            end
         end
         if (done) begin
            chk(prev_acc && q_addr.size() == 0, "R10", "done timing, pending",
                q_addr.size(), 32'h0);
            if (r_pc.size() == 0) begin
               chk(1'b0, "R12", "unexpected done", 32'h1, 32'h0);
            end else begin
               logic [15:0] p;
               logic [7:0]  s, b;
               logic [5:0]  f;
               string       t;
               p = r_pc.pop_front(); s = r_sp.pop_front(); f = r_fl.pop_front();
               b = r_by.pop_front(); t = r_tag.pop_front();
               chk(pc_out == p, t, "pc_out", {16'h0, pc_out}, {16'h0, p});
               chk(sp_out == s, t, "sp_out", {24'h0, sp_out}, {24'h0, s});
               chk(flags_out == f, t, "flags_out", {26'h0, flags_out}, {26'h0, f});
               chk(byte_out == b, t, "byte_out", {24'h0, byte_out}, {24'h0, b});
            end
         end
         prev_acc = mem_rd || mem_wr;
      end
   end

   // driver: builds expectations, then starts the sequence
   task automatic run_op(logic [2:0] o, logic [15:0] p0, logic [7:0] s0,
                         logic [5:0] f0, logic [7:0] b0, int poke, string tag);
      logic [15:0] p;
      logic [7:0]  s, lo, hi, by;
      logic [5:0]  f;
      int          cnt;
      p = p0; s = s0; f = f0; by = b0;
      case (o)
         3'd3: begin exp_wr({8'h01, s}, b0, tag); s--; end
         3'd5: begin exp_wr({8'h01, s}, pack(f0), tag); s--; end
         3'd4, 3'd6: begin
            exp_rd({8'h01, s}, tag); s++;
            exp_rd({8'h01, s}, tag);
            if (o == 3'd4) by = exp_stk[s]; else f = unpack(exp_stk[s]);
         end
         3'd1: begin
            exp_rd(p, tag); lo = peek(p); p++;
            exp_rd({8'h01, s}, tag);
            exp_wr({8'h01, s}, p[15:8], tag); s--;
            exp_wr({8'h01, s}, p[7:0], tag); s--;
            exp_rd(p, tag); hi = peek(p);
            p = {hi, lo};
         end
         3'd2: begin
            exp_rd(p, tag);
            exp_rd({8'h01, s}, tag); s++;
            exp_rd({8'h01, s}, tag); lo = exp_stk[s]; s++;
            exp_rd({8'h01, s}, tag); hi = exp_stk[s];
            p = {hi, lo};
            exp_rd(p, tag); p++;
         end
         default: begin
            exp_rd(p, tag); p++;
            exp_wr({8'h01, s}, p[15:8], tag); s--;
            exp_wr({8'h01, s}, p[7:0], tag); s--;
            exp_wr({8'h01, s}, pack(f0), tag); s--;
            f[2] = 1'b1;
            exp_rd(16'hFFFE, tag); exp_rd(16'hFFFF, tag);
            p = {pat(16'hFFFF), pat(16'hFFFE)};
         end
      endcase
      r_pc.push_back(p); r_sp.push_back(s); r_fl.push_back(f);
      r_by.push_back(by); r_tag.push_back(tag);
      op = o; pc_in = p0; sp_in = s0; flags_in = f0; byte_in = b0; start = 1'b1;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
         if (cnt == poke) begin start = 1'b1; op = 3'd3; end
         else start = 1'b0;
      end while (!done);
      start = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         stk[i] = 8'(i) ^ 8'hC3;
         exp_stk[i] = 8'(i) ^ 8'hC3;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!mem_rd && !mem_wr && !done, "R1", "strobes", {29'h0, mem_rd, mem_wr, done}, 32'h0);
      chk(pc_out == 0 && sp_out == 0 && flags_out == 0 && byte_out == 0, "R1", "outputs",
          {pc_out, sp_out, 2'b0, flags_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      run_op(3'd3, 16'h1234, 8'h80, 6'b010101, 8'hA5, 0, "R3");
      run_op(3'd4, 16'h1234, 8'h7F, 6'b000000, 8'h11, 0, "R4");
      run_op(3'd5, 16'h4321, 8'h40, 6'b101011, 8'h22, 0, "R5");
      run_op(3'd6, 16'h4321, 8'h3F, 6'b000000, 8'h33, 0, "R6");
      run_op(3'd3, 16'h0000, 8'h20, 6'b000000, 8'hCF, 0, "R6");
      run_op(3'd6, 16'h0000, 8'h1F, 6'b000000, 8'h44, 0, "R6");
      run_op(3'd3, 16'h0000, 8'h30, 6'b000000, 8'h30, 0, "R6");
      run_op(3'd6, 16'h0000, 8'h2F, 6'b111111, 8'h44, 0, "R6");
      run_op(3'd1, 16'h0300, 8'hFF, 6'b000010, 8'h55, 0, "R7");
      run_op(3'd2, 16'h5859, 8'hFD, 6'b000010, 8'h66, 0, "R8");
      run_op(3'd0, 16'h2000, 8'h10, 6'b000000, 8'h77, 0, "R9");
      run_op(3'd0, 16'hABCD, 8'h02, 6'b111011, 8'h78, 0, "R9");
      run_op(3'd3, 16'h0000, 8'h00, 6'b000000, 8'h9C, 0, "R11");
      run_op(3'd4, 16'h0000, 8'hFF, 6'b000000, 8'h00, 0, "R11");
      run_op(3'd1, 16'h0800, 8'h01, 6'b000000, 8'h00, 0, "R11");
      // R12: start pulse during a running break and a running call
      run_op(3'd0, 16'h3000, 8'hE0, 6'b100000, 8'h12, 2, "R12");
      run_op(3'd1, 16'h0500, 8'hC0, 6'b000001, 8'h12, 3, "R12");
      // R12: reserved operation code is ignored
      op = 3'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(!mem_rd && !mem_wr && !done, "R12", "reserved op activity",
             {29'h0, mem_rd, mem_wr, done}, 32'h0);
         @(negedge clk);
      end
      chk(q_addr.size() == 0 && r_pc.size() == 0, "R10", "queues drained",
          q_addr.size() + r_pc.size(), 32'h0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule